// File: doc/BRIEF.md
# Programmable Clock Pattern Channel Bank

This block is a bank of independent digital channels that generate repeating clock waveforms for an image sensor. Each channel keeps a 16-bit waveform word and a start delay. When a trigger arrives, the channel waits out the delay. It then replays the word one bit per base-clock cycle, over and over, until it is disabled. No processor needs to step it during playback. A per-channel polarity bit inverts the waveform and sets the idle level. A per-channel direction mode makes the pad an output, an input or high impedance.

Software sets each channel through a narrow write port. Each write selects a channel, one of three fields and a data word. Delays are whole base-clock cycles. With the default 16-bit counter and a 100 MHz clock, the delay reaches several hundred microseconds. When a channel is in input mode, the value on its pad is captured into a readable vector every cycle.

Top module: `clkpat_bank`

## Requirements
- R1: During and after reset, with no writes, every `pin_out`, `pin_oe` and `in_sample` bit is 0, and every channel is disabled, non-inverted and in high-impedance mode.
- R2: When `wr_en` is high, a write updates only channel `wr_ch`. The field is chosen by `wr_sel`:
  - 0 loads the waveform word.
  - 1 loads the delay D.
  - 2 loads the control field: bit 0 enable, bit 1 invert, bits 3:2 mode.
  - Mode codes are 01 output, 10 input, and 00 or 11 high impedance.
- R3: A trigger on an enabled channel, sampled at clock edge t, holds that channel at its idle level through edge t+D. Bit 0 of the waveform word is shown after edge t+D+1.
- R4: After the first bit, the channel shows bit j of the word after edge t+D+1+j, one bit per cycle. After bit 15 it wraps to bit 0, for as long as the channel stays enabled.
- R5: `pin_out` equals the waveform bit XOR the invert bit. The idle level equals the invert bit.
- R6: From the cycle after a write that clears the enable, `pin_out` is at the idle level. A trigger on a disabled channel is ignored.
- R7: A write to the waveform word or the delay does not alter playback already started. A trigger in the same cycle as such a write uses the values held before the write.
- R8: A trigger on a channel that is waiting or playing restarts it from the beginning of its delay.
- R9: `pin_oe` of a channel is 1 exactly when its mode is output. It changes only in the cycle after a control write.
- R10: In input mode, `in_sample` takes the channel's `pin_in` value at every clock edge. In the other modes it holds its last value.
- R11: Channels are independent: writes and triggers on one channel leave every other channel's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_ch | input | 5 | Channel addressed by the write |
| wr_sel | input | 2 | Field select: 0 waveform, 1 delay, 2 control |
| wr_data | input | 16 | Write data |
| trig | input | 32 | Per-channel start/restart trigger |
| pin_in | input | 32 | Pad input values |
| pin_out | output | 32 | Pad drive values |
| pin_oe | output | 32 | Pad output enables |
| in_sample | output | 32 | Captured pad inputs of channels in input mode |

## Verification
Three pairs of events can fall in the same cycle:
- a waveform or delay write and a trigger on the same channel;
- a control write that clears the enable and a trigger on that channel;
- a retrigger and the cycle in which the waveform wraps.

Random stimulus with dense writes and sparse triggers produces these collisions across all channels. Directed steps force the waveform-write-plus-trigger case on one channel. A bench model predicts each output from the requirements alone. It keeps, per channel, the word and delay in force at the last accepted trigger and the edge count since that trigger. Every pad output is compared against it each cycle.

// File: rtl/clkpat_bank.sv
module clkpat_bank #(
  parameter int NCH   = 32,
  parameter int PAT_W = 16,
  parameter int DLY_W = 16,
  localparam int CH_W  = $clog2(NCH),
  localparam int IDX_W = $clog2(PAT_W),
  localparam int DAT_W = (PAT_W > DLY_W) ? PAT_W : DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [1:0]       wr_sel,
  input  logic [DAT_W-1:0] wr_data,
  input  logic [NCH-1:0]   trig,
  input  logic [NCH-1:0]   pin_in,
  output logic [NCH-1:0]   pin_out,
  output logic [NCH-1:0]   pin_oe,
  output logic [NCH-1:0]   in_sample
);
  localparam logic [1:0] SEL_PAT = 2'd0;
  localparam logic [1:0] SEL_DLY = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;
  localparam logic [1:0] M_OUT   = 2'b01;
  localparam logic [1:0] M_IN    = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} st_t;

  logic [NCH-1:0]       en_q;
  logic [NCH-1:0]       inv_q;
  logic [NCH-1:0][1:0]  mode_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic             hit;
    logic [PAT_W-1:0] pat_r, act_r;
    logic [DLY_W-1:0] dly_r, cnt_r;
    logic [IDX_W-1:0] idx_r;
    logic             en_r, inv_r, smp_r;
    logic [1:0]       mode_r;
    st_t              st_r;

    assign hit = wr_en && (wr_ch == CH_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pat_r  <= '0;
        dly_r  <= '0;
        en_r   <= 1'b0;
        inv_r  <= 1'b0;
        mode_r <= 2'b00;
      end else if (hit) begin
        if (wr_sel == SEL_PAT) pat_r <= wr_data[PAT_W-1:0];
        if (wr_sel == SEL_DLY) dly_r <= wr_data[DLY_W-1:0];
        if (wr_sel == SEL_CTL) {mode_r, inv_r, en_r} <= wr_data[3:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= ST_IDLE;
        act_r <= '0;
        cnt_r <= '0;
        idx_r <= '0;
      end else if (!en_r) begin
        st_r <= ST_IDLE;
      end else if (trig[i]) begin
        act_r <= pat_r;
        cnt_r <= dly_r;
        idx_r <= '0;
        st_r  <= ST_WAIT;
      end else begin
        case (st_r)
          ST_WAIT: begin
            if (cnt_r == '0) st_r <= ST_RUN;
            else             cnt_r <= cnt_r - 1'b1;
          end
          ST_RUN:  idx_r <= (idx_r == IDX_W'(PAT_W-1)) ? '0 : idx_r + 1'b1;
          default: st_r <= ST_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               smp_r <= 1'b0;
      else if (mode_r == M_IN)  smp_r <= pin_in[i];
    end

    assign en_q[i]      = en_r;
    assign inv_q[i]     = inv_r;
    assign mode_q[i]    = mode_r;
    assign in_sample[i] = smp_r;
    assign pin_oe[i]    = (mode_r == M_OUT);
    assign pin_out[i]   = ((st_r == ST_RUN) && en_r) ? (act_r[idx_r] ^ inv_r) : inv_r;
  end
endmodule

// File: rtl/clkpat_bank_chk.sv
module clkpat_bank_chk #(
  parameter int NCH = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [NCH-1:0]      trig,
  input logic [NCH-1:0]      pin_out,
  input logic [NCH-1:0]      pin_oe,
  input logic [NCH-1:0]      in_sample,
  input logic [NCH-1:0]      en_q,
  input logic [NCH-1:0]      inv_q,
  input logic [NCH-1:0][1:0] mode_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_trig_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[i] && en_q[i]) |=> (pin_out[i] == inv_q[i]));

    p_disable_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q[i]) |-> (pin_out[i] == inv_q[i]));

    p_oe_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_oe[i]) |-> $past(wr_en));

    p_sample_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(in_sample[i]) |-> ($past(mode_q[i]) == 2'b10));
  end
endmodule

bind clkpat_bank clkpat_bank_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .trig(trig),
  .pin_out(pin_out), .pin_oe(pin_oe), .in_sample(in_sample),
  .en_q(en_q), .inv_q(inv_q), .mode_q(mode_q)
);

// File: tb/clkpat_bank_tb_top.sv
module clkpat_bank_tb_top;
  localparam int NCH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_ch = '0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [NCH-1:0] trig = '0, pin_in = '0;
  logic [NCH-1:0] pin_out, pin_oe, in_sample;

  always #10 clk = ~clk;

  clkpat_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .trig(trig), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .in_sample(in_sample)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [15:0] pat_m[NCH], dly_m[NCH], apat[NCH], adly[NCH];
  logic        en_m[NCH], inv_m[NCH], run_m[NCH], smp_m[NCH];
  logic [1:0]  mode_m[NCH];
  int          ts[NCH];

  function automatic logic exp_out(int i);
    int k;
    if (!(run_m[i] && en_m[i])) return inv_m[i];
    k = cyc - ts[i];
    if (k <= int'(adly[i])) return inv_m[i];
    return apat[i][(k - int'(adly[i]) - 1) % 16] ^ inv_m[i];
  endfunction

  function automatic string out_tag(int i);
    if (!en_m[i]) return "R6";
    if (!run_m[i]) return "R5";
    if ((cyc - ts[i]) <= int'(adly[i])) return "R3";
    return "R4";
  endfunction

  task automatic chk(string tag, logic act, logic exp, int ch);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ch%0d cyc%0d actual=%b expected=%b", tag, ch, cyc, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NCH; i++) begin
      chk((tag != "") ? tag : out_tag(i), pin_out[i], exp_out(i), i);
      chk("R9", pin_oe[i], mode_m[i] == 2'b01, i);
      chk("R10", in_sample[i], smp_m[i], i);
    end
  endtask

  // one clock edge: model update at the edge, output check at the next falling edge
  task automatic step(string tag);
    @(posedge clk);
    #1;
    cyc++;
    for (int i = 0; i < NCH; i++) begin
      if (!en_m[i]) run_m[i] = 0;
      else if (trig[i]) begin
        apat[i] = pat_m[i]; adly[i] = dly_m[i]; ts[i] = cyc; run_m[i] = 1;
      end
      if (mode_m[i] == 2'b10) smp_m[i] = pin_in[i];
    end
    if (wr_en) begin
      case (wr_sel)
        2'd0: pat_m[wr_ch] = wr_data;
        2'd1: dly_m[wr_ch] = wr_data;
        2'd2: begin
          en_m[wr_ch] = wr_data[0]; inv_m[wr_ch] = wr_data[1]; mode_m[wr_ch] = wr_data[3:2];
        end
        default: ;
      endcase
    end
    @(negedge clk);
    check_all(tag);
    wr_en = 0; trig = '0;
  endtask

  task automatic wr(int ch, int sel, logic [15:0] d, logic [NCH-1:0] t, string tag);
    wr_en = 1; wr_ch = 5'(ch); wr_sel = 2'(sel); wr_data = d; trig = t;
    step(tag);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NCH; i++) begin
      pat_m[i] = 0; dly_m[i] = 0; apat[i] = 0; adly[i] = 0; en_m[i] = 0;
      inv_m[i] = 0; run_m[i] = 0; smp_m[i] = 0; mode_m[i] = 0; ts[i] = 0;
    end
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // R2 R5 R3 R4: channel 3, inverted output, delay 3, wrap over 40 cycles
    wr(3, 0, 16'hA5C3, '0, "R2");
    wr(3, 1, 16'd3, '0, "R2");
    wr(3, 2, 16'h0007, '0, "R2");
    wr(3, 2, 16'h0007, NCH'(1) << 3, "R3");
    repeat (40) step("");
    // R7: new word and delay while playing, trigger together with a write
    wr(3, 0, 16'h0F0F, '0, "R7");
    wr(3, 1, 16'd0, '0, "R7");
    repeat (5) step("R7");
    wr(3, 0, 16'h1234, NCH'(1) << 3, "R7");
    repeat (20) step("");
    // R8: retrigger mid-run; R11: channel 4 starts meanwhile
    wr(4, 2, 16'h0005, NCH'(1) << 3, "R8");
    wr(4, 0, 16'h8001, NCH'(1) << 4, "R11");
    repeat (20) step("");
    // R6: disable while playing, trigger on disabled channel
    wr(3, 2, 16'h0006, NCH'(1) << 3, "R6");
    repeat (4) step("R6");
    trig = NCH'(1) << 3;
    step("R6");
    // R10: input mode on channel 5
    wr(5, 2, 16'h0008, '0, "R10");
    for (int n = 0; n < 6; n++) begin
      pin_in = $urandom; step("R10");
    end

    // constrained random with collisions across all channels
    for (int n = 0; n < 6000; n++) begin
      pin_in = $urandom;
      wr_en = ($urandom % 3) == 0;
      wr_ch = 5'($urandom);
      wr_sel = 2'($urandom % 3);
      case (wr_sel)
        2'd1: wr_data = (($urandom % 8) == 0) ? 16'($urandom % 200) : 16'($urandom % 20);
        2'd2: wr_data = {12'd0, (($urandom % 4) == 0) ? 2'($urandom) : 2'b01,
                         1'($urandom), (($urandom % 5) != 0)};
        default: wr_data = 16'($urandom);
      endcase
      for (int i = 0; i < NCH; i++) trig[i] = ($urandom % 40) == 0;
      step("");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule